// File: doc/BRIEF.md
# Serial ADC Setup and Readout Sequencer

This block sits on the host side of a two-wire serial link to an external sampling converter. After reset it waits for the converter's power-up self-calibration. It then serves user requests. Each request names an input channel, picks how the conversion is started (a low pulse on a dedicated start pin, or a start bit written over the link) and picks when the result is read: during the conversion, which returns the previous result, or after busy falls, which returns the new one.

The link uses one shared data line for both directions, so frames never overlap. The line direction changes only while the frame sync is idle. When the channel differs from the one last configured, the sequencer writes the control word with the mode bit and the channel. It then waits an acquisition time before it starts the conversion. A request may instead ask for the channel change and the software start to be merged into one write. In that case the acquisition time is skipped and the result of that conversion comes back flagged for discard.

All waits are counts of system clock cycles, set by parameters. The serial clock is the system clock divided by 2*DIV.

Top module: `adc_link_seq`

## Requirements
- R1: After reset, seq_busy stays high for CAL_CYC cycles. During that time no frame is sent, cnv_n stays high, and any request is refused with req_reject high. At reset, sync_n=1, cnv_n=1, dio_oe=0 and rsp_valid=0.
- R2: A frame holds sync_n low for exactly 16 serial clock periods of 2*DIV cycles each. sclk is low whenever sync_n is high. Bits travel MSB first. Each bit is set up while sclk is low and taken on the rising sclk edge.
- R3: A write frame carries the control word: bit 15=1, bits 14:13=0, bit 12=1 (two-wire mode), bit 11=start, bits 10:8=channel and bits 7:0=0.
- R4: On the first request, or on a channel change, a configuration write with start=0 is sent first. At least ACQ_CYC cycles then pass before the start action begins. A request on the channel already configured sends no configuration write.
- R5: A software start sends one write with start=1. A pin start sends no write and drives cnv_n low for exactly PULSE_CYC cycles.
- R6: dio_oe is high only inside write frames. Between any two frames, sync_n stays high for at least 2*DIV cycles.
- R7: In read-during mode, the read frame starts DLY_CYC cycles after the start action ends, whatever the state of busy_in. rsp_data is the previous conversion's result, and rsp_discard is that conversion's discard flag.
- R8: In read-after mode, the read frame waits for busy_in to be low. rsp_data is the current conversion's result.
- R9: When req_merge is set with a software start and a channel change, a single write with start=1 and the new channel is sent, and no acquisition wait follows. That conversion's result carries rsp_discard=1. Later conversions carry 0. req_merge has no effect when there is no channel change, or when the start is by pin.
- R10: rsp_valid is a one-cycle pulse, and rsp_data holds the low 12 bits of the read frame. A request made while seq_busy is high is refused with req_reject and has no effect on the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_chan | input | CH_W | Channel to convert |
| req_after | input | 1 | 1: read after busy falls; 0: read during the conversion |
| req_sw | input | 1 | 1: start by written bit; 0: start by pin pulse |
| req_merge | input | 1 | Merge the channel change into the software start write |
| seq_busy | output | 1 | Calibration or a sequence is in progress |
| req_reject | output | 1 | The request is refused in this cycle |
| rsp_valid | output | 1 | Result strobe |
| rsp_data | output | RES_W | Result word |
| rsp_discard | output | 1 | The result should be dropped |
| sclk | output | 1 | Serial clock |
| sync_n | output | 1 | Frame sync, active low |
| dio_out | output | 1 | Data line value driven by the host |
| dio_oe | output | 1 | Data line output enable |
| dio_in | input | 1 | Data line value seen from the converter |
| cnv_n | output | 1 | Conversion start pin, pulsed low |
| busy_in | input | 1 | Converter busy |

## Verification
The hardest situation to reach is a discard flag arriving through a read-during request. The flag belongs to the earlier, merged conversion, not to the conversion being started. The stimulus first changes the channel with a merged software start and reads after busy falls. It then issues a read-during request on the same channel, which must return that merged result with its flag still set. A converter model on the bench raises busy for a fixed time, keeps its last result, and records every written word and frame timing. The sweep covers all channels and every start and read mode. A refused request is injected mid-sequence in every run, and the write count shows it had no effect.

// File: rtl/adc_link_seq.sv
module adc_link_seq #(
  parameter int DIV       = 4,
  parameter int CAL_CYC   = 128000,
  parameter int ACQ_CYC   = 8,
  parameter int DLY_CYC   = 20,
  parameter int PULSE_CYC = 4,
  parameter int CH_W      = 3,
  parameter int RES_W     = 12,
  parameter int FRM_W     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [CH_W-1:0] req_chan,
  input  logic            req_after,
  input  logic            req_sw,
  input  logic            req_merge,
  output logic            seq_busy,
  output logic            req_reject,
  output logic            rsp_valid,
  output logic [RES_W-1:0] rsp_data,
  output logic            rsp_discard,
  output logic            sclk,
  output logic            sync_n,
  output logic            dio_out,
  output logic            dio_oe,
  input  logic            dio_in,
  output logic            cnv_n,
  input  logic            busy_in
);
  localparam int PW = (2*DIV > 1) ? $clog2(2*DIV) : 1;
  localparam int BW = $clog2(FRM_W);
  localparam int TW = $clog2(CAL_CYC + ACQ_CYC + DLY_CYC + PULSE_CYC + 2*DIV + 2);

  typedef enum logic [3:0] {
    S_CAL, S_IDLE, S_CFG, S_CFG_GAP, S_ACQ, S_GO, S_GO_GAP,
    S_PULSE, S_DLY, S_WAITB, S_RD, S_RD_GAP, S_DONE
  } st_t;

  st_t             st;
  logic [TW-1:0]   tmr;
  logic [PW-1:0]   ph;
  logic [BW-1:0]   bitn;
  logic [FRM_W-1:0] sh;
  logic            cfg_ok, cur_disc, prev_disc;
  logic [CH_W-1:0] cur_ch, r_ch;
  logic            r_after, r_sw, r_mrg;

  function automatic logic [FRM_W-1:0] ctl_word(input logic start, input logic [CH_W-1:0] ch);
    logic [FRM_W-1:0] w;
    w = '0;
    w[FRM_W-1] = 1'b1;
    w[12] = 1'b1;
    w[11] = start;
    w[8 +: CH_W] = ch;
    return w;
  endfunction

  wire in_frm   = (st == S_CFG) || (st == S_GO) || (st == S_RD);
  wire ph_last  = ph == PW'(2*DIV-1);
  wire ph_mid   = ph == PW'(DIV-1);
  wire frm_end  = in_frm && ph_last && (bitn == BW'(FRM_W-1));
  wire tmr_zero = tmr == '0;
  wire need_cfg = !cfg_ok || (req_chan != cur_ch);
  wire tmr_cal  = tmr_zero;

  assign seq_busy    = st != S_IDLE;
  assign req_reject  = req_valid && seq_busy;
  assign rsp_valid   = st == S_DONE;
  assign rsp_data    = sh[RES_W-1:0];
  assign rsp_discard = r_after ? cur_disc : prev_disc;
  assign sync_n      = !in_frm;
  assign sclk        = in_frm && (ph >= PW'(DIV));
  assign dio_oe      = (st == S_CFG) || (st == S_GO);
  assign dio_out     = dio_oe && sh[FRM_W-1];
  assign cnv_n       = st != S_PULSE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_CAL;
      tmr       <= TW'(CAL_CYC-1);
      ph        <= '0;
      bitn      <= '0;
      sh        <= '0;
      cfg_ok    <= 1'b0;
      cur_ch    <= '0;
      r_ch      <= '0;
      r_after   <= 1'b0;
      r_sw      <= 1'b0;
      r_mrg     <= 1'b0;
      cur_disc  <= 1'b0;
      prev_disc <= 1'b0;
    end else begin
      if (in_frm) begin
        ph <= ph_last ? '0 : ph + 1'b1;
        if (ph_last) bitn <= bitn + 1'b1;
        if (st == S_RD && ph_mid) sh <= {sh[FRM_W-2:0], dio_in};
        if (st != S_RD && ph_last) sh <= {sh[FRM_W-2:0], 1'b0};
      end
      case (st)
        S_CAL: if (tmr_cal) st <= S_IDLE; else tmr <= tmr - 1'b1;
        S_IDLE: if (req_valid) begin
          r_ch    <= req_chan;
          r_after <= req_after;
          r_sw    <= req_sw;
          r_mrg   <= req_sw && req_merge && need_cfg;
          ph      <= '0;
          bitn    <= '0;
          if (need_cfg) begin
            st <= S_CFG;
            sh <= ctl_word(req_sw && req_merge, req_chan);
          end else if (req_sw) begin
            st <= S_GO;
            sh <= ctl_word(1'b1, req_chan);
          end else begin
            st  <= S_PULSE;
            tmr <= TW'(PULSE_CYC-1);
          end
        end
        S_CFG: if (frm_end) begin
          st     <= S_CFG_GAP;
          tmr    <= TW'(2*DIV-1);
          cfg_ok <= 1'b1;
          cur_ch <= r_ch;
          if (r_mrg) begin
            prev_disc <= cur_disc;
            cur_disc  <= 1'b1;
          end
        end
        S_CFG_GAP: if (!tmr_zero) tmr <= tmr - 1'b1;
          else if (r_mrg) begin st <= S_DLY; tmr <= TW'(DLY_CYC-1); end
          else begin st <= S_ACQ; tmr <= TW'(ACQ_CYC-1); end
        S_ACQ: if (!tmr_zero) tmr <= tmr - 1'b1;
          else if (r_sw) begin
            st   <= S_GO;
            sh   <= ctl_word(1'b1, r_ch);
            ph   <= '0;
            bitn <= '0;
          end else begin
            st  <= S_PULSE;
            tmr <= TW'(PULSE_CYC-1);
          end
        S_GO: if (frm_end) begin
          st        <= S_GO_GAP;
          tmr       <= TW'(2*DIV-1);
          prev_disc <= cur_disc;
          cur_disc  <= 1'b0;
        end
        S_GO_GAP: if (!tmr_zero) tmr <= tmr - 1'b1;
          else begin st <= S_DLY; tmr <= TW'(DLY_CYC-1); end
        S_PULSE: if (!tmr_zero) tmr <= tmr - 1'b1;
          else begin
            st        <= S_DLY;
            tmr       <= TW'(DLY_CYC-1);
            prev_disc <= cur_disc;
            cur_disc  <= 1'b0;
          end
        S_DLY: if (!tmr_zero) tmr <= tmr - 1'b1;
          else if (r_after) st <= S_WAITB;
          else begin st <= S_RD; sh <= '0; ph <= '0; bitn <= '0; end
        S_WAITB: if (!busy_in) begin
          st <= S_RD; sh <= '0; ph <= '0; bitn <= '0;
        end
        S_RD: if (frm_end) begin st <= S_RD_GAP; tmr <= TW'(2*DIV-1); end
        S_RD_GAP: if (!tmr_zero) tmr <= tmr - 1'b1; else st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r6_idle_no_drive: assert property (@(posedge clk) disable iff (!rst_n) sync_n |-> !dio_oe);
  a_r2_idle_clk_low:  assert property (@(posedge clk) disable iff (!rst_n) sync_n |-> !sclk);
  a_r6_turnaround:    assert property (@(posedge clk) disable iff (!rst_n) $rose(sync_n) |=> sync_n);
  a_r5_pin_no_frame:  assert property (@(posedge clk) disable iff (!rst_n) !cnv_n |-> sync_n);
  a_r10_one_pulse:    assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid);
  a_r10_refuse:       assert property (@(posedge clk) disable iff (!rst_n) (req_valid && seq_busy) |=> $stable(r_ch) || seq_busy);
  a_r1_cal_quiet:     assert property (@(posedge clk) disable iff (!rst_n) (st == S_CAL) |-> (sync_n && cnv_n && seq_busy));
  a_r8_wait_busy:     assert property (@(posedge clk) disable iff (!rst_n) (st == S_WAITB && busy_in) |=> sync_n);
endmodule

// File: tb/sim_adc_link_seq.sv
module sim_adc_link_seq;
  localparam int DIV = 2, CAL = 200, ACQ = 6, DLY = 5, PUL = 3, CONV = 150;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 1'b0, req_after = 1'b0, req_sw = 1'b0, req_merge = 1'b0;
  logic [2:0] req_chan = '0;
  logic seq_busy, req_reject, rsp_valid, rsp_discard, sclk, sync_n, dio_out, dio_oe, dio_in, cnv_n;
  logic busy_in = 1'b0;
  logic [11:0] rsp_data;

  adc_link_seq #(.DIV(DIV), .CAL_CYC(CAL), .ACQ_CYC(ACQ), .DLY_CYC(DLY), .PULSE_CYC(PUL)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan), .req_after(req_after),
    .req_sw(req_sw), .req_merge(req_merge), .seq_busy(seq_busy), .req_reject(req_reject),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_discard(rsp_discard), .sclk(sclk),
    .sync_n(sync_n), .dio_out(dio_out), .dio_oe(dio_oe), .dio_in(dio_in), .cnv_n(cnv_n),
    .busy_in(busy_in));

  int total = 0, bad = 0;
  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] rval(input logic [2:0] ch, input int idx);
    return {ch, 9'(idx)};
  endfunction
  function automatic logic [15:0] cw(input logic st, input logic [2:0] ch);
    return {1'b1, 2'b00, 1'b1, st, ch, 8'h00};
  endfunction

  // converter model
  logic psync = 1'b1, psclk = 1'b0, pcnv = 1'b1, frm_wr = 1'b0, seen = 1'b0, acq_armed = 1'b0;
  logic [4:0] rcnt = 5'd16;
  logic [15:0] rword = '0, wsh = '0;
  logic [15:0] wlog [0:255];
  logic [2:0] m_ch = '0;
  logic [11:0] adc_reg = '0, pend = '0;
  int nw = 0, rises = 0, low_len = 0, hi_len = 0, pul_len = 0, since_cfg = 1000000;
  int m_idx = 0, cctr = 0;
  int err_len = 0, err_gap = 0, err_clk = 0, err_oe = 0, err_pul = 0, err_acq = 0;

  assign dio_in = rcnt[4] ? 1'b0 : rword[~rcnt[3:0]];

  always @(negedge clk) if (rst_n) begin
    if (cctr > 0) begin
      cctr--;
      if (cctr == 0) begin busy_in = 1'b0; adc_reg = pend; end
    end
    if (psync && !sync_n) begin
      if (seen && hi_len < 2*DIV) err_gap++;
      low_len = 0; rcnt = 0; rises = 0; frm_wr = 1'b0; rword = {4'hC, adc_reg};
      if (acq_armed && since_cfg < ACQ) err_acq++;
      acq_armed = 1'b0;
    end
    if (!sync_n) low_len++; else hi_len++;
    if (sync_n && sclk) err_clk++;
    if (sync_n && dio_oe) err_oe++;
    if (!sync_n && sclk && !psclk) begin
      if (rises == 0) frm_wr = dio_oe; else if (dio_oe != frm_wr) err_oe++;
      wsh = {wsh[14:0], dio_out};
      rises++;
      rcnt = rcnt + 5'd1;
    end
    if (!psync && sync_n) begin
      seen = 1'b1; hi_len = 1;
      if (low_len != 32*DIV) err_len++;
      if (rises != 16) err_clk++;
      if (frm_wr) begin
        wlog[nw] = wsh; nw++; m_ch = wsh[10:8];
        if (wsh[11]) begin
          busy_in = 1'b1; cctr = CONV; pend = rval(wsh[10:8], m_idx); m_idx++;
        end else begin
          acq_armed = 1'b1; since_cfg = 0;
        end
      end
    end
    since_cfg++;
    if (pcnv && !cnv_n) begin
      pul_len = 1;
      if (acq_armed && since_cfg < ACQ) err_acq++;
      acq_armed = 1'b0;
    end else if (!pcnv && !cnv_n) pul_len++;
    if (!pcnv && cnv_n) begin
      if (pul_len != PUL) err_pul++;
      busy_in = 1'b1; cctr = CONV; pend = rval(m_ch, m_idx); m_idx++;
    end
    psync = sync_n; psclk = sclk; pcnv = cnv_n;
  end

  // bench expectations
  logic b_ok = 1'b0, b_ldisc = 1'b0;
  logic [2:0] b_ch = '0;
  logic [11:0] b_last = '0;
  int b_idx = 0;

  task automatic run_req(input logic [2:0] ch, input logic after, input logic sw, input logic mrg);
    logic need, merged, edisc;
    logic [11:0] v, ed;
    logic [15:0] w0;
    int nexp, nw0;
    @(negedge clk);
    while (seq_busy || busy_in) @(negedge clk);
    need = !b_ok || ch != b_ch;
    merged = sw && mrg && need;
    v = rval(ch, b_idx); b_idx++;
    ed = after ? v : b_last;
    edisc = after ? merged : b_ldisc;
    b_last = v; b_ldisc = merged; b_ok = 1'b1; b_ch = ch;
    nexp = (need ? 1 : 0) + ((sw && !merged) ? 1 : 0);
    w0 = need ? cw(merged, ch) : cw(1'b1, ch);
    nw0 = nw;
    req_chan = ch; req_after = after; req_sw = sw; req_merge = mrg; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 accepted busy", int'(seq_busy), 1);
    repeat (20) @(negedge clk);
    req_chan = ~ch; req_sw = ~sw; req_valid = 1'b1;
    #1 chk("R10 refused", int'(req_reject), 1);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    chk(after ? "R8 result" : "R7 result", int'(rsp_data), int'(ed));
    chk(merged ? "R9 discard" : (after ? "R8 discard" : "R7 discard"), int'(rsp_discard), int'(edisc));
    #1;
    chk("R4 R5 R10 write count", nw - nw0, nexp);
    if (nexp >= 1) chk("R3 first word", int'(wlog[nw0]), int'(w0));
    if (nexp == 2) chk("R3 start word", int'(wlog[nw0+1]), int'(cw(1'b1, ch)));
    @(negedge clk);
    chk("R10 strobe one cycle", int'(rsp_valid), 0);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 reset sync_n", int'(sync_n), 1);
    chk("R1 reset cnv_n", int'(cnv_n), 1);
    chk("R1 reset dio_oe", int'(dio_oe), 0);
    chk("R1 reset rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;
    repeat (50) @(negedge clk);
    req_valid = 1'b1;
    #1 chk("R1 refused in calibration", int'(req_reject), 1);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (CAL - 56) @(negedge clk);
    chk("R1 busy in calibration", int'(seq_busy), 1);
    chk("R1 no frame in calibration", nw + int'(seen), 0);
    repeat (10) @(negedge clk);
    chk("R1 idle after calibration", int'(seq_busy), 0);

    for (int ch = 0; ch < 8; ch++)
      for (int m = 0; m < 4; m++)
        run_req(3'(ch), m[0], m[1], 1'b0);

    run_req(3'd3, 1'b1, 1'b1, 1'b1);
    run_req(3'd3, 1'b0, 1'b1, 1'b1);
    run_req(3'd3, 1'b1, 1'b1, 1'b0);
    run_req(3'd5, 1'b0, 1'b1, 1'b1);
    run_req(3'd5, 1'b1, 1'b0, 1'b1);
    run_req(3'd6, 1'b1, 1'b0, 1'b1);
    run_req(3'd1, 1'b0, 1'b1, 1'b1);
    run_req(3'd1, 1'b0, 1'b0, 1'b0);

    repeat (20) @(negedge clk);
    chk("R2 frame length", err_len, 0);
    chk("R2 serial clock", err_clk, 0);
    chk("R6 turnaround", err_gap, 0);
    chk("R6 line drive", err_oe, 0);
    chk("R5 pulse width", err_pul, 0);
    chk("R4 acquisition wait", err_acq, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule